// File: doc/BRIEF.md
# Hysteretic Power-Good Window Monitor

This block decides whether a regulator output counts as "good". On each sample strobe it compares a digitised feedback code against four limits. All four limits are derived in fixed point from a reference code. Two limits form an upper band and two form a lower band, and each band has its own trip point and its own release point. A trip sets that band's fault latch, and the latch stays set until the feedback passes back through the band's release point. Between strobes, each latch holds its state.

The single output follows open-drain semantics: 1 means released (good) and 0 means pulled low. The output releases only when four things are all true: the block is enabled, the sequencer has reported that soft-start is complete, and neither fault latch is set. Dropping enable pulls the output low in the same cycle and clears both latches. The block is meant to sit between an ADC sample stream and the rail sequencer.

Top module: `pgood_window_mon`

## Requirements
- R1: A synchronous active-high `rst` clears both fault latches and the soft-start flag. `pgood` reads 0 while `rst` is high and stays 0 after reset until soft-start completion is seen again.
- R2: When `en` is 0, `pgood` is 0 in that same cycle, without waiting for a clock edge or a strobe.
- R3: After enable, `pgood` stays 0 until `ss_done` is sampled high at a clock edge while `en` is 1. It may release from the edge after that.
- R4: On a strobe, a feedback code strictly greater than (ref × 1137) >> 10 sets the over-voltage latch, and `pgood` is 0 after that edge. A code equal to this limit does not trip.
- R5: Once set, the over-voltage latch clears only on a strobe whose feedback code is at most (ref × 1101) >> 10. Codes between the two limits keep it set.
- R6: On a strobe, a feedback code strictly less than (ref × 911) >> 10 sets the under-voltage latch, and `pgood` is 0 after that edge. A code equal to this limit does not trip.
- R7: Once set, the under-voltage latch clears only on a strobe whose feedback code is at least (ref × 947) >> 10.
- R8: A cycle without `smp_vld` leaves both latches unchanged, whatever the feedback code is.
- R9: `pgood` is 1 only when neither fault latch is set. If one strobe clears one latch and sets the other, the output stays low.
- R10: Taking `en` low clears both fault latches. After a re-enable followed by soft-start completion, the output releases with no strobe needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Regulator enable; 0 forces the output low and clears the fault latches |
| ss_done | input | 1 | Soft-start completed flag from the sequencer |
| smp_vld | input | 1 | Feedback sample strobe; thresholds are evaluated only on this cycle |
| fb_code | input | CODE_W | Digitised feedback voltage |
| ref_code | input | CODE_W | Reference code from which all four limits are derived |
| pgood | output | 1 | Power-good, 1 = released, 0 = pulled low |

## Verification
The bench builds the block with a 12-bit code width and the default 10-bit fraction.

With a reference of 2048, every limit is an exact integer (2274, 2202, 1822, 1894). This lets the bench step the feedback to one code on either side of each trip and release point and show that trip and release happen at distinct codes.

A second pass uses the full-scale reference of 4095. Here the truncated products (3643 and 3787 for the lower band) and an upper trip limit above the code range check the rounding-down behaviour and that the threshold arithmetic does not overflow.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    // Fixed-point fraction width of the threshold multipliers
    localparam int unsigned FRAC_W = 10;

    // Multipliers (value / 2^FRAC_W) for the four window limits
    localparam int unsigned K_OV_TRIP = 1137;
    localparam int unsigned K_OV_REL  = 1101;
    localparam int unsigned K_UV_TRIP = 911;
    localparam int unsigned K_UV_REL  = 947;

    localparam int unsigned N_LIMITS = 4;

    // Index of each limit in the threshold vector
    typedef enum logic [1:0] {
        LIM_OV_TRIP = 2'd0,
        LIM_OV_REL  = 2'd1,
        LIM_UV_TRIP = 2'd2,
        LIM_UV_REL  = 2'd3
    } lim_idx_e;

    // Which side of the window a hysteresis band guards
    typedef enum logic {
        SIDE_HIGH = 1'b0,
        SIDE_LOW  = 1'b1
    } band_side_e;

    function automatic int unsigned lim_mult(input int unsigned idx);
        case (idx)
            0:       return K_OV_TRIP;
            1:       return K_OV_REL;
            2:       return K_UV_TRIP;
            default: return K_UV_REL;
        endcase
    endfunction

    // (ref * k) >> FRAC_W, truncating
    function automatic logic [31:0] scale_ref(input logic [31:0] ref_v,
                                              input logic [31:0] k);
        logic [31:0] prod;
        prod = ref_v * k;
        return prod >> FRAC_W;
    endfunction

endpackage

// File: rtl/pgw_thresh.sv
module pgw_thresh #(
    parameter int unsigned CODE_W = 12,
    parameter int unsigned TH_W   = CODE_W + 1
) (
    input  logic [CODE_W-1:0]                     ref_code,
    output logic [pgw_pkg::N_LIMITS-1:0][TH_W-1:0] lim
);
    import pgw_pkg::*;

    for (genvar g = 0; g < int'(N_LIMITS); g++) begin : g_lim
        localparam logic [31:0] K_G = 32'(lim_mult(g));
        logic [31:0] wide;
        always_comb wide = scale_ref(32'(ref_code), K_G);
        assign lim[g] = wide[TH_W-1:0];
        logic unused_hi;
        assign unused_hi = ^wide[31:TH_W];
    end

endmodule

// File: rtl/pgw_band.sv
module pgw_band #(
    parameter int unsigned          TH_W = 13,
    parameter pgw_pkg::band_side_e  SIDE = pgw_pkg::SIDE_HIGH
) (
    input  logic            clk,
    input  logic            clr,
    input  logic            smp,
    input  logic [TH_W-1:0] fb,
    input  logic [TH_W-1:0] trip_lim,
    input  logic [TH_W-1:0] rel_lim,
    output logic            flt_q
);
    import pgw_pkg::*;

    logic trip_hit;
    logic rel_hit;

    if (SIDE == SIDE_HIGH) begin : g_high
        assign trip_hit = fb > trip_lim;
        assign rel_hit  = fb <= rel_lim;
    end else begin : g_low
        assign trip_hit = fb < trip_lim;
        assign rel_hit  = fb >= rel_lim;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            flt_q <= 1'b0;
        end else if (smp) begin
            if (trip_hit) begin
                flt_q <= 1'b1;
            end else if (rel_hit) begin
                flt_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pgw_gate.sv
module pgw_gate (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ss_done,
    input  logic ov_flt,
    input  logic uv_flt,
    output logic pgood
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= en & (armed_q | ss_done);
        end
    end

    assign pgood = ~rst & en & armed_q & ~ov_flt & ~uv_flt;

endmodule

// File: rtl/pgood_window_mon.sv
module pgood_window_mon #(
    parameter int unsigned CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              ss_done,
    input  logic              smp_vld,
    input  logic [CODE_W-1:0] fb_code,
    input  logic [CODE_W-1:0] ref_code,
    output logic              pgood
);
    import pgw_pkg::*;

    localparam int unsigned TH_W = CODE_W + 1;

    logic [N_LIMITS-1:0][TH_W-1:0] lim;
    logic [TH_W-1:0]               fb_ext;
    logic                          flt_clr;
    logic                          ov_flt;
    logic                          uv_flt;

    assign fb_ext  = {1'b0, fb_code};
    assign flt_clr = rst | ~en;

    pgw_thresh #(.CODE_W(CODE_W), .TH_W(TH_W)) u_thresh (
        .ref_code (ref_code),
        .lim      (lim)
    );

    pgw_band #(.TH_W(TH_W), .SIDE(SIDE_HIGH)) u_ov_band (
        .clk      (clk),
        .clr      (flt_clr),
        .smp      (smp_vld),
        .fb       (fb_ext),
        .trip_lim (lim[LIM_OV_TRIP]),
        .rel_lim  (lim[LIM_OV_REL]),
        .flt_q    (ov_flt)
    );

    pgw_band #(.TH_W(TH_W), .SIDE(SIDE_LOW)) u_uv_band (
        .clk      (clk),
        .clr      (flt_clr),
        .smp      (smp_vld),
        .fb       (fb_ext),
        .trip_lim (lim[LIM_UV_TRIP]),
        .rel_lim  (lim[LIM_UV_REL]),
        .flt_q    (uv_flt)
    );

    pgw_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .ss_done (ss_done),
        .ov_flt  (ov_flt),
        .uv_flt  (uv_flt),
        .pgood   (pgood)
    );

endmodule

// File: rtl/pgood_window_mon_chk.sv
module pgood_window_mon_chk #(
    parameter int unsigned CODE_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              smp_vld,
    input logic [CODE_W-1:0] fb_code,
    input logic [CODE_W-1:0] ref_code,
    input logic              pgood,
    input logic              ov_flt,
    input logic              uv_flt
);
    int unsigned fbv, ov_t, ov_r, uv_t, uv_r;

    always_comb begin
        fbv  = 32'(fb_code);
        ov_t = (32'(ref_code) * 32'd1137) >> 10;
        ov_r = (32'(ref_code) * 32'd1101) >> 10;
        uv_t = (32'(ref_code) * 32'd911) >> 10;
        uv_r = (32'(ref_code) * 32'd947) >> 10;
    end

    p_reset_low_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pgood);

    p_en_low_r2: assert property (@(posedge clk) disable iff (rst)
        !en |-> !pgood);

    p_ov_trip_r4: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && en && fbv > ov_t) |=> (ov_flt && !pgood));

    p_ov_release_r5: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && en && fbv <= ov_r) |=> !ov_flt);

    p_uv_trip_r6: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && en && fbv < uv_t) |=> (uv_flt && !pgood));

    p_uv_release_r7: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && en && fbv >= uv_r) |=> !uv_flt);

    p_hold_no_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        (!smp_vld && en) |=> ($stable(ov_flt) && $stable(uv_flt)));

    p_release_clean_r9: assert property (@(posedge clk) disable iff (rst)
        pgood |-> (!ov_flt && !uv_flt));

    p_disable_clears_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!ov_flt && !uv_flt));

endmodule

bind pgood_window_mon pgood_window_mon_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .smp_vld  (smp_vld),
    .fb_code  (fb_code),
    .ref_code (ref_code),
    .pgood    (pgood),
    .ov_flt   (ov_flt),
    .uv_flt   (uv_flt)
);

// File: tb/pgood_window_mon_tb.sv
module pgood_window_mon_tb;

    localparam int unsigned CODE_W = 12;
    localparam int unsigned WDOG   = 100000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en = 1'b0;
    logic              ss_done = 1'b0;
    logic              smp_vld = 1'b0;
    logic [CODE_W-1:0] fb_code = '0;
    logic [CODE_W-1:0] ref_code = 12'd2048;
    logic              pgood;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pgood_window_mon #(.CODE_W(CODE_W)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .ss_done  (ss_done),
        .smp_vld  (smp_vld),
        .fb_code  (fb_code),
        .ref_code (ref_code),
        .pgood    (pgood)
    );

    typedef struct packed {
        logic              v_en;
        logic              v_ss;
        logic              v_smp;
        logic [CODE_W-1:0] v_fb;
        logic              v_exp;
        logic [7:0]        v_req;
    } vec_t;

    // Reference 2048: OV trip 2274, OV release 2202, UV trip 1822, UV release 1894
    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b1, 12'd2048, 1'b0, 8'd3},  // R3 no soft-start yet
        '{1'b1, 1'b1, 1'b1, 12'd2048, 1'b1, 8'd3},  // R3 released
        '{1'b1, 1'b1, 1'b1, 12'd2274, 1'b1, 8'd4},  // R4 at limit, no trip
        '{1'b1, 1'b1, 1'b1, 12'd2275, 1'b0, 8'd4},  // R4 trip
        '{1'b1, 1'b1, 1'b1, 12'd2203, 1'b0, 8'd5},  // R5 inside hysteresis
        '{1'b1, 1'b1, 1'b0, 12'd2000, 1'b0, 8'd8},  // R8 no strobe
        '{1'b1, 1'b1, 1'b1, 12'd2202, 1'b1, 8'd5},  // R5 release
        '{1'b1, 1'b1, 1'b1, 12'd1822, 1'b1, 8'd6},  // R6 at limit, no trip
        '{1'b1, 1'b1, 1'b1, 12'd1821, 1'b0, 8'd6},  // R6 trip
        '{1'b1, 1'b1, 1'b1, 12'd1893, 1'b0, 8'd7},  // R7 inside hysteresis
        '{1'b1, 1'b1, 1'b0, 12'd2048, 1'b0, 8'd8},  // R8 no strobe
        '{1'b1, 1'b1, 1'b1, 12'd1894, 1'b1, 8'd7},  // R7 release
        '{1'b1, 1'b1, 1'b1, 12'd3000, 1'b0, 8'd4},  // R4 large excursion
        '{1'b1, 1'b1, 1'b1, 12'd1000, 1'b0, 8'd9},  // R9 OV cleared, UV set
        '{1'b1, 1'b1, 1'b1, 12'd2048, 1'b1, 8'd9},  // R9 both clear
        '{1'b1, 1'b1, 1'b0, 12'd4000, 1'b1, 8'd8}   // R8 no strobe, no trip
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(input logic exp, input string tag);
        n_chk++;
        if (pgood !== exp) begin
            n_fail++;
            $display("FAIL %s: pgood=%0b expected %0b at %0t", tag, pgood, exp, $time);
        end
    endtask

    // Apply one cycle of stimulus at the falling edge, sample 1 ns after the rising edge
    task automatic step(input logic e, input logic s, input logic sv, input logic [CODE_W-1:0] fb);
        @(negedge clk);
        en = e; ss_done = s; smp_vld = sv; fb_code = fb;
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, WDOG);
            summary();
            $finish;
        end
    end

    initial begin
        // R1: held in reset
        step(1'b1, 1'b1, 1'b0, 12'd2048);
        step(1'b1, 1'b1, 1'b0, 12'd2048);
        chk(1'b0, "R1 during reset");
        @(negedge clk);
        rst = 1'b0; en = 1'b0; ss_done = 1'b0;
        #1;
        chk(1'b0, "R1 after reset release");

        // Vector table sweep
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].v_en, VECS[i].v_ss, VECS[i].v_smp, VECS[i].v_fb);
            chk(VECS[i].v_exp, $sformatf("R%0d vector %0d", VECS[i].v_req, i));
        end

        // R2: enable low drops output without any edge
        @(negedge clk);
        smp_vld = 1'b0;
        en = 1'b0;
        #1;
        chk(1'b0, "R2 immediate drop");

        // R10: trip OV, disable, re-enable, release with no strobe
        step(1'b1, 1'b1, 1'b0, 12'd2048);
        step(1'b1, 1'b1, 1'b0, 12'd2048);
        chk(1'b1, "R3 re-armed");
        step(1'b1, 1'b1, 1'b1, 12'd2500);
        chk(1'b0, "R4 trip before disable");
        step(1'b0, 1'b0, 1'b0, 12'd2500);
        chk(1'b0, "R2 disabled");
        step(1'b1, 1'b0, 1'b0, 12'd2500);
        chk(1'b0, "R3 waiting for soft-start");
        step(1'b1, 1'b1, 1'b0, 12'd2500);
        chk(1'b1, "R10 latch cleared by disable");

        // R1: reset clears a set latch
        step(1'b1, 1'b1, 1'b1, 12'd1500);
        chk(1'b0, "R6 trip before reset");
        @(negedge clk);
        rst = 1'b1; smp_vld = 1'b0;
        @(posedge clk);
        #1;
        chk(1'b0, "R1 reset asserted");
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(1'b0, "R1 soft-start flag cleared");
        @(posedge clk);
        #1;
        chk(1'b1, "R1 latch cleared by reset");

        // Full-scale reference 4095: UV trip 3643, UV release 3787, OV trip 4546
        ref_code = 12'd4095;
        step(1'b1, 1'b1, 1'b1, 12'd4095);
        chk(1'b1, "R4 full-scale code below OV limit");
        step(1'b1, 1'b1, 1'b1, 12'd3643);
        chk(1'b1, "R6 truncated limit, no trip");
        step(1'b1, 1'b1, 1'b1, 12'd3642);
        chk(1'b0, "R6 truncated limit trip");
        step(1'b1, 1'b1, 1'b1, 12'd3786);
        chk(1'b0, "R7 one below truncated release");
        step(1'b1, 1'b1, 1'b1, 12'd3787);
        chk(1'b1, "R7 truncated release");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule